// File: doc/BRIEF.md
# Total-Store-Order Store Buffer

This block sits between one core's load/store request port and a single-ported memory. It gives that core total-store-order behaviour. A store is accepted into a small in-order queue and written to memory on a later cycle. A load is answered in the cycle it is presented, without waiting for older queued stores. Loads therefore pass earlier stores, while stores stay ordered among themselves and loads stay ordered among themselves.

The core sees its own queued stores. A load whose address matches one or more queued entries returns the youngest matching value. Two requests give the core back the store-then-load ordering. A fence holds the core until the queue is empty. A locked fetch-and-add first empties the queue, then reads memory and writes back the sum. The memory accepts a write only in a cycle where it signals write-ready, so queued stores can build up while that signal is low.

Top module: `tso_store_buffer`

## Requirements
- R1: After reset the queue is empty. With no request, `req_stall`, `mem_we`, `mem_re`, `rsp_valid` and `fence_done` are all low.
- R2: A store (`req_op` = 2'b00) presented while the queue holds fewer than DEPTH entries is accepted in that cycle with `req_stall` low. It is not written to memory in that cycle.
- R3: Queued stores are written to memory oldest first, one per cycle. `mem_we` is high whenever the queue is non-empty and the port is not taken by a load. An entry leaves the queue only in a cycle where `mem_wready` is high.
- R4: A load (`req_op` = 2'b01) is answered in the same cycle, with `rsp_valid` high and `req_stall` low, even while older stores are still queued. With no matching queued entry, the response is the memory value.
- R5: A load whose address matches queued stores returns the data of the youngest matching entry.
- R6: In a cycle carrying a load, the memory port performs the read and no queued store is written.
- R7: A store presented while DEPTH entries are queued raises `req_stall`. The store is accepted once an entry has drained.
- R8: A fence (`req_op` = 2'b10) raises `req_stall` while the queue is non-empty. `fence_done` pulses, with `req_stall` low, in the first cycle the queue is empty.
- R9: An atomic (`req_op` = 2'b11) stalls until the queue is empty. It then reads memory, with `req_stall` still high. From the next cycle it drives a write of old value plus `req_wdata`, held until `mem_wready`. In that accepting cycle it returns the old value with `rsp_valid` high and `req_stall` low.
- R10: `mem_we` and `mem_re` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Core request present; held while stalled |
| req_op | input | 2 | 00 store, 01 load, 10 fence, 11 atomic add |
| req_addr | input | AW | Request word address |
| req_wdata | input | DW | Store data or atomic addend |
| req_stall | output | 1 | Request not consumed this cycle |
| rsp_valid | output | 1 | Load or atomic result valid |
| rsp_rdata | output | DW | Load or atomic (old) value |
| fence_done | output | 1 | Fence completes this cycle |
| mem_we | output | 1 | Memory write request |
| mem_re | output | 1 | Memory read this cycle |
| mem_addr | output | AW | Memory address |
| mem_wdata | output | DW | Memory write data |
| mem_wready | input | 1 | Memory accepts the write this cycle |
| mem_rdata | input | DW | Combinational read data for `mem_addr` |

## Verification
Load responses, stall, `fence_done` and the memory request lines are all combinational in the current request and queue state, so each is due in the very cycle its stimulus is driven. A stored value can appear on `mem_we` no earlier than the cycle after its push. An atomic's write and result come one cycle after its read at the earliest, and later by one cycle for each low `mem_wready`. The bench drives inputs on the falling edge and samples one time unit later. In that window it compares every output against a behavioural queue-and-memory model stepped once per cycle, so each result is checked exactly in its due cycle.

// File: rtl/tso_sb_pkg.sv
package tso_sb_pkg;
    typedef enum logic [1:0] {
        OP_STORE  = 2'b00,
        OP_LOAD   = 2'b01,
        OP_FENCE  = 2'b10,
        OP_ATOMIC = 2'b11
    } sb_op_e;

    typedef enum logic {
        PH_RUN    = 1'b0,
        PH_AMO_WR = 1'b1
    } sb_phase_e;
endpackage

// File: rtl/tso_sb_queue.sv
module tso_sb_queue #(
    parameter int DEPTH = 4,
    parameter int AW    = 8,
    parameter int DW    = 32,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           push,
    input  logic [AW-1:0]                  push_addr,
    input  logic [DW-1:0]                  push_data,
    input  logic                           pop,
    output logic [AW-1:0]                  head_addr,
    output logic [DW-1:0]                  head_data,
    output logic [PW-1:0]                  head_ptr,
    output logic [CW-1:0]                  count,
    output logic                           empty,
    output logic                           full,
    output logic [DEPTH-1:0][AW-1:0]       ent_addr,
    output logic [DEPTH-1:0][DW-1:0]       ent_data
);
    typedef struct packed {
        logic [DEPTH-1:0][AW-1:0] addr;
        logic [DEPTH-1:0][DW-1:0] data;
        logic [PW-1:0]            head;
        logic [PW-1:0]            tail;
        logic [CW-1:0]            count;
    } q_t;

    q_t q_q, q_d;

    function automatic logic [PW-1:0] step_ptr(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    always_comb begin
        q_d = q_q;
        if (pop) begin
            q_d.head = step_ptr(q_q.head);
        end
        if (push) begin
            q_d.addr[q_q.tail] = push_addr;
            q_d.data[q_q.tail] = push_data;
            q_d.tail           = step_ptr(q_q.tail);
        end
        q_d.count = q_q.count + CW'(push) - CW'(pop);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_q <= '0;
        else        q_q <= q_d;
    end

    assign head_addr = q_q.addr[q_q.head];
    assign head_data = q_q.data[q_q.head];
    assign head_ptr  = q_q.head;
    assign count     = q_q.count;
    assign empty     = (q_q.count == '0);
    assign full      = (q_q.count == CW'(DEPTH));
    assign ent_addr  = q_q.addr;
    assign ent_data  = q_q.data;

    // R7: the controller never pushes into a full queue
    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);

    // R3: a drain only ever removes an existing entry
    assert_no_underflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
endmodule

// File: rtl/tso_sb_fwd.sv
module tso_sb_fwd #(
    parameter int DEPTH = 4,
    parameter int AW    = 8,
    parameter int DW    = 32,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic [DEPTH-1:0][AW-1:0] ent_addr,
    input  logic [DEPTH-1:0][DW-1:0] ent_data,
    input  logic [PW-1:0]            head_ptr,
    input  logic [CW-1:0]            count,
    input  logic [AW-1:0]            ld_addr,
    output logic                     hit,
    output logic [DW-1:0]            hit_data
);
    // Scan oldest to youngest; a later match overrides, so the youngest wins.
    always_comb begin
        hit      = 1'b0;
        hit_data = '0;
        for (int i = 0; i < DEPTH; i++) begin
            logic [PW-1:0] slot;
            slot = PW'((int'(head_ptr) + i) % DEPTH);
            if ((CW'(i) < count) && (ent_addr[slot] == ld_addr)) begin
                hit      = 1'b1;
                hit_data = ent_data[slot];
            end
        end
    end
endmodule

// File: rtl/tso_store_buffer.sv
module tso_store_buffer
    import tso_sb_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int AW    = 8,
    parameter int DW    = 32,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [1:0]    req_op,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic          req_stall,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_rdata,
    output logic          fence_done,
    output logic          mem_we,
    output logic          mem_re,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic          mem_wready,
    input  logic [DW-1:0] mem_rdata
);
    typedef struct packed {
        sb_phase_e     phase;
        logic [AW-1:0] amo_addr;
        logic [DW-1:0] amo_old;
        logic [DW-1:0] amo_new;
    } ctl_t;

    ctl_t ctl_q, ctl_d;

    logic                     q_push, q_pop, q_empty, q_full;
    logic [AW-1:0]            head_addr;
    logic [DW-1:0]            head_data;
    logic [PW-1:0]            head_ptr;
    logic [CW-1:0]            q_count;
    logic [DEPTH-1:0][AW-1:0] ent_addr;
    logic [DEPTH-1:0][DW-1:0] ent_data;
    logic                     fwd_hit;
    logic [DW-1:0]            fwd_data;
    logic                     drain_want;
    sb_op_e                   op;

    assign op = sb_op_e'(req_op);

    tso_sb_queue #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_queue (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (q_push),
        .push_addr (req_addr),
        .push_data (req_wdata),
        .pop       (q_pop),
        .head_addr (head_addr),
        .head_data (head_data),
        .head_ptr  (head_ptr),
        .count     (q_count),
        .empty     (q_empty),
        .full      (q_full),
        .ent_addr  (ent_addr),
        .ent_data  (ent_data)
    );

    tso_sb_fwd #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_fwd (
        .ent_addr (ent_addr),
        .ent_data (ent_data),
        .head_ptr (head_ptr),
        .count    (q_count),
        .ld_addr  (req_addr),
        .hit      (fwd_hit),
        .hit_data (fwd_data)
    );

    always_comb begin
        ctl_d      = ctl_q;
        req_stall  = 1'b0;
        rsp_valid  = 1'b0;
        rsp_rdata  = '0;
        fence_done = 1'b0;
        mem_we     = 1'b0;
        mem_re     = 1'b0;
        mem_addr   = '0;
        mem_wdata  = '0;
        q_push     = 1'b0;
        q_pop      = 1'b0;
        drain_want = 1'b0;
        case (ctl_q.phase)
            PH_AMO_WR: begin
                mem_we    = 1'b1;
                mem_addr  = ctl_q.amo_addr;
                mem_wdata = ctl_q.amo_new;
                if (mem_wready) begin
                    rsp_valid   = 1'b1;
                    rsp_rdata   = ctl_q.amo_old;
                    ctl_d.phase = PH_RUN;
                end else begin
                    req_stall = 1'b1;
                end
            end
            default: begin
                drain_want = !q_empty;
                if (req_valid) begin
                    unique case (op)
                        OP_STORE: begin
                            if (q_full) req_stall = 1'b1;
                            else        q_push    = 1'b1;
                        end
                        OP_LOAD: begin
                            drain_want = 1'b0;
                            mem_re     = 1'b1;
                            mem_addr   = req_addr;
                            rsp_valid  = 1'b1;
                            rsp_rdata  = fwd_hit ? fwd_data : mem_rdata;
                        end
                        OP_FENCE: begin
                            if (!q_empty) req_stall  = 1'b1;
                            else          fence_done = 1'b1;
                        end
                        OP_ATOMIC: begin
                            req_stall = 1'b1;
                            if (q_empty) begin
                                mem_re         = 1'b1;
                                mem_addr       = req_addr;
                                ctl_d.phase    = PH_AMO_WR;
                                ctl_d.amo_addr = req_addr;
                                ctl_d.amo_old  = mem_rdata;
                                ctl_d.amo_new  = mem_rdata + req_wdata;
                            end
                        end
                    endcase
                end
                if (drain_want) begin
                    mem_we    = 1'b1;
                    mem_addr  = head_addr;
                    mem_wdata = head_data;
                    q_pop     = mem_wready;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '{phase: PH_RUN, default: '0};
        else        ctl_q <= ctl_d;
    end

    // R10: one memory port, never a read and a write together
    assert_single_port_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && mem_re));

    // R8: fence completes only on an empty queue with no write pending
    assert_fence_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fence_done |-> (q_count == '0) && !mem_we);

    // R7: a store against a full queue is held off
    assert_full_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && ctl_q.phase == PH_RUN && req_op == OP_STORE && q_full) |-> req_stall);

    // R4: a load in the run phase never waits
    assert_load_now_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && ctl_q.phase == PH_RUN && req_op == OP_LOAD) |-> (rsp_valid && !req_stall));

    // R9: an atomic read is followed by a write to the same address
    assert_amo_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_re && ctl_q.phase == PH_RUN && req_op == OP_ATOMIC)
            |=> (mem_we && mem_addr == $past(req_addr)));
endmodule

// File: tb/sim_tso_store_buffer.sv
module sim_tso_store_buffer;
    localparam int  CLK_PERIOD = 10;
    localparam int  DEPTH      = 4;
    localparam int  AW         = 8;
    localparam int  DW         = 32;
    localparam int  MEMN       = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [1:0]    req_op = 2'b00;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          req_stall, rsp_valid, fence_done, mem_we, mem_re;
    logic [DW-1:0] rsp_rdata, mem_wdata, mem_rdata;
    logic [AW-1:0] mem_addr;
    logic          mem_wready = 1'b1;

    logic [DW-1:0] bmem [MEMN];
    logic [DW-1:0] ref_mem [MEMN];

    int errors = 0;
    int checks = 0;
    int hold   = 0;

    logic [AW-1:0] sq_a[$];
    logic [DW-1:0] sq_d[$];
    bit            amo_ph = 0;
    logic [AW-1:0] amo_addr;
    logic [DW-1:0] amo_old, amo_new;

    always #(CLK_PERIOD / 2) clk = ~clk;

    tso_store_buffer #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_stall(req_stall),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .fence_done(fence_done),
        .mem_we(mem_we), .mem_re(mem_re), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_wready(mem_wready), .mem_rdata(mem_rdata)
    );

    assign mem_rdata = bmem[mem_addr];
    always @(posedge clk) if (mem_we && mem_wready) bmem[mem_addr] <= mem_wdata;

    task automatic check(string tag, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic cycle(bit v, logic [1:0] op, logic [AW-1:0] a, logic [DW-1:0] d,
                         output bit stalled);
        bit rdy, e_stall, e_rsp, e_we, e_re, e_done, can_drain, push_it, hit;
        logic [DW-1:0] e_rd, e_wd;
        logic [AW-1:0] e_wa, e_ra;
        string tag, wtag;
        @(negedge clk);
        rdy = (hold == 0);
        if (hold > 0) hold--;
        req_valid = v; req_op = op; req_addr = a; req_wdata = d; mem_wready = rdy;
        #1;
        e_stall = 0; e_rsp = 0; e_we = 0; e_re = 0; e_done = 0; push_it = 0; hit = 0;
        e_rd = '0; e_wd = '0; e_wa = '0; e_ra = '0;
        tag = "R3"; wtag = "R3";
        if (amo_ph) begin
            tag = "R9"; wtag = "R9";
            e_we = 1; e_wa = amo_addr; e_wd = amo_new;
            if (rdy) begin
                e_rsp = 1; e_rd = amo_old; ref_mem[amo_addr] = amo_new; amo_ph = 0;
            end else e_stall = 1;
        end else begin
            can_drain = (sq_a.size() > 0);
            if (v) begin
                case (op)
                    2'b00: begin
                        if (sq_a.size() == DEPTH) begin e_stall = 1; tag = "R7"; end
                        else begin push_it = 1; tag = "R2"; end
                    end
                    2'b01: begin
                        can_drain = 0; e_re = 1; e_ra = a; e_rsp = 1; wtag = "R6";
                        e_rd = ref_mem[a];
                        for (int k = sq_a.size() - 1; k >= 0; k--)
                            if (!hit && sq_a[k] == a) begin hit = 1; e_rd = sq_d[k]; end
                        tag = hit ? "R5" : "R4";
                    end
                    2'b10: begin
                        tag = "R8";
                        if (sq_a.size() > 0) e_stall = 1; else e_done = 1;
                    end
                    default: begin
                        tag = "R9";
                        e_stall = 1;
                        if (sq_a.size() == 0) begin
                            e_re = 1; e_ra = a; amo_ph = 1; amo_addr = a;
                            amo_old = ref_mem[a]; amo_new = ref_mem[a] + d;
                        end
                    end
                endcase
            end
            if (can_drain) begin
                e_we = 1; e_wa = sq_a[0]; e_wd = sq_d[0];
                if (rdy) begin
                    ref_mem[sq_a[0]] = sq_d[0];
                    void'(sq_a.pop_front()); void'(sq_d.pop_front());
                end
            end
            if (push_it) begin sq_a.push_back(a); sq_d.push_back(d); end
        end
        check(tag, "req_stall", DW'(req_stall), DW'(e_stall));
        check(tag, "rsp_valid", DW'(rsp_valid), DW'(e_rsp));
        if (e_rsp) check(tag, "rsp_rdata", rsp_rdata, e_rd);
        check("R8", "fence_done", DW'(fence_done), DW'(e_done));
        check(wtag, "mem_we", DW'(mem_we), DW'(e_we));
        if (e_we) begin
            check(wtag, "mem_addr(wr)", DW'(mem_addr), DW'(e_wa));
            check(wtag, "mem_wdata", mem_wdata, e_wd);
        end
        check(tag, "mem_re", DW'(mem_re), DW'(e_re));
        if (e_re) check(tag, "mem_addr(rd)", DW'(mem_addr), DW'(e_ra));
        check("R10", "we&re", DW'(mem_we && mem_re), '0);
        stalled = e_stall;
    endtask

    task automatic req(bit v, logic [1:0] op, logic [AW-1:0] a, logic [DW-1:0] d);
        bit st;
        do cycle(v, op, a, d, st); while (st);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) req(0, 2'b00, '0, '0);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < MEMN; i++) begin
            bmem[i]    = 32'h1000 + i * 7;
            ref_mem[i] = 32'h1000 + i * 7;
        end
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #1;
        // R1: idle outputs right after reset
        check("R1", "req_stall", DW'(req_stall), '0);
        check("R1", "mem_we", DW'(mem_we), '0);
        check("R1", "mem_re", DW'(mem_re), '0);
        check("R1", "rsp_valid", DW'(rsp_valid), '0);
        check("R1", "fence_done", DW'(fence_done), '0);
        idle(2);

        // R2 R4 R5: queued stores, forwarding and bypass while the port refuses writes
        hold = 8;
        req(1, 2'b00, 8'h10, 32'd1);
        req(1, 2'b00, 8'h10, 32'd2);
        req(1, 2'b00, 8'h20, 32'd7);
        req(1, 2'b01, 8'h10, '0);
        req(1, 2'b01, 8'h20, '0);
        req(1, 2'b01, 8'h30, '0);
        idle(6);

        // R6: a load holds off a ready drain
        req(1, 2'b00, 8'h40, 32'd5);
        req(1, 2'b01, 8'h41, '0);
        idle(3);

        // R7: fill the queue, then stall until a slot drains
        hold = 7;
        for (int i = 0; i < DEPTH + 1; i++) req(1, 2'b00, AW'(8'h50 + i), DW'(100 + i));
        idle(4);

        // R8: fence waits for the queue to empty
        hold = 6;
        req(1, 2'b00, 8'h60, 32'd11);
        req(1, 2'b00, 8'h61, 32'd12);
        req(1, 2'b00, 8'h62, 32'd13);
        req(1, 2'b10, '0, '0);
        req(1, 2'b01, 8'h61, '0);
        req(1, 2'b10, '0, '0);

        // R9: atomic after queued stores, then with a delayed write accept
        hold = 2;
        req(1, 2'b00, 8'h70, 32'd100);
        req(1, 2'b11, 8'h70, 32'd5);
        req(1, 2'b01, 8'h70, '0);
        hold = 3;
        req(1, 2'b11, 8'h71, 32'd9);
        req(1, 2'b01, 8'h71, '0);

        // mixed traffic over a small address range
        for (int n = 0; n < 400; n++) begin
            int r;
            r = $urandom % 10;
            if ($urandom % 8 == 0) hold = $urandom % 4;
            if (r < 4)       req(1, 2'b00, AW'($urandom % 6), DW'($urandom));
            else if (r < 7) req(1, 2'b01, AW'($urandom % 6), '0);
            else if (r == 7) req(1, 2'b10, '0, '0);
            else if (r == 8) req(1, 2'b11, AW'($urandom % 6), DW'($urandom % 50));
            else             idle(1);
        end
        idle(8);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule